// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detect

This block is a general-purpose I/O controller for `NPIN` pins, where `NPIN` is a multiple of 32 and defaults to 64. Software reaches it over a simple 32-bit read/write bus with byte addresses. Each read or write is one word.

The pins are split into banks of 32. Each feature owns a contiguous run of words, with one word per bank:

- level readback
- direction
- one-shot set and clear of the output value
- rising-edge and falling-edge enables
- a sticky edge status that is cleared by writing a one

A final run holds 2-bit alternate-function selects, packed 16 pins per word.

The controller drives output-enable and output-value vectors to the pads and presents the function selects to the peripheral mux. The pad inputs pass through a two-flop synchronizer before they are read back or examined for edges. A single level interrupt is asserted while any edge status bit is set.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, all writable state is zero. Every pin is an input (`pin_oe`=0) with `pin_out`=0, `alt_sel`=0, no edge enabled, no status bit set and `irq`=0.
- R2: With NBANK=NPIN/32, the word for feature group g and bank b sits at byte address g*NBANK*4 + b*4. The groups are: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 alternate function. Pin p uses bank p/32 and bit p%32 in every one-bit-per-pin group.
- R3: A direction bit of 1 makes the pin an output, which `pin_oe` shows. A 0 makes it an input. The direction word reads back as written.
- R4: Writing a 1 to a bit of a set word drives that pin's `pin_out` high. Writing a 1 to a bit of a clear word drives it low. Zero bits leave the pin unchanged. Set and clear words always read 0.
- R5: A level word returns the synchronized pin inputs, two clocks behind `pin_in`. Writes to a level word have no effect.
- R6: An edge status bit becomes set when the synchronized input of its pin shows a rising edge with the rising enable set, or a falling edge with the falling enable set. An edge whose enable is 0 sets nothing.
- R7: Writing a 1 to an edge status bit clears it. Zero bits leave status unchanged.
- R8: If a new enabled edge on a pin lands in the same cycle as a clearing write to its status bit, the bit stays set.
- R9: `irq` is 1 exactly while any edge status bit in any bank is 1.
- R10: The alternate-function field of pin p lives in word 7*NBANK + p/16 at bits (p%16)*2+1:(p%16)*2. It reads back and drives `alt_sel[2p+1:2p]`. The value 0 means plain GPIO.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe. A read from an address beyond the last alternate-function word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per word |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address, AW = clog2(9*NBANK*4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPIN | Raw pad input levels |
| pin_oe | output | NPIN | Per-pin output enable |
| pin_out | output | NPIN | Per-pin output value |
| alt_sel | output | 2*NPIN | Per-pin function select, 2 bits per pin |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
A wrong bank or group decode shows up as soon as the write lands. The wrong bit moves on `pin_oe`, `pin_out` or `alt_sel` one clock later, and a readback of the intended word comes back stale.

Edge-detection faults take longer to surface. They appear three clocks after the pad change, as a missing or spurious `irq` and a wrong status word.

A wrong clear-versus-edge priority can only be seen with a tightly timed clear. The write must coincide with the detected edge, and `irq` must stay high afterwards.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [3:0] {
    GRP_LVL = 4'd0,
    GRP_DIR = 4'd1,
    GRP_SET = 4'd2,
    GRP_CLR = 4'd3,
    GRP_REN = 4'd4,
    GRP_FEN = 4'd5,
    GRP_STS = 4'd6,
    GRP_ALT = 4'd7,
    GRP_NONE = 4'd8
  } grp_e;

  // Which feature group a word index belongs to.
  function automatic grp_e word_group(int unsigned widx, int unsigned nbank);
    int unsigned g;
    if (widx >= 9 * nbank) return GRP_NONE;
    g = widx / nbank;
    if (g >= 7) return GRP_ALT;
    return grp_e'(g[3:0]);
  endfunction

  // Index of the word inside its group (bank, or half-bank for ALT).
  function automatic int unsigned word_slot(int unsigned widx, int unsigned nbank);
    int unsigned g;
    g = widx / nbank;
    if (g >= 7) return widx - 7 * nbank;
    return widx - g * nbank;
  endfunction

  // New edge status: keep unless cleared, an edge always wins.
  function automatic logic [31:0] status_next(logic [31:0] cur, logic [31:0] clr,
                                              logic [31:0] evt);
    return (cur & ~clr) | evt;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_in;
      stage2 <= stage1;
    end
  end

  assign q_out = stage2;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int NBANK = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NBANK*32-1:0]   lvl,
  input  logic [NBANK*32-1:0]   rise_en,
  input  logic [NBANK*32-1:0]   fall_en,
  input  logic [NBANK*32-1:0]   clr_mask,
  output logic [NBANK*32-1:0]   evt,
  output logic [NBANK*32-1:0]   status
);
  import gpio_pkg::*;
  localparam int W = NBANK * 32;

  logic [W-1:0] lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= '0;
    else        lvl_prev <= lvl;
  end

  assign evt = (lvl & ~lvl_prev & rise_en) | (~lvl & lvl_prev & fall_en);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[b*32 +: 32] <= '0;
      else status[b*32 +: 32] <= status_next(status[b*32 +: 32], clr_mask[b*32 +: 32],
                                             evt[b*32 +: 32]);
    end
  end

  // R7: a written one with no competing edge leaves the bit clear
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~evt)) |=> ((status & $past(clr_mask & ~evt)) == '0));
  // R8: a detected edge always lands, even under a clearing write
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status & $past(evt)) == $past(evt)));
  // R6: no status bit rises without a detected enabled edge
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(evt)) == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int NBANK = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           wdata,
  input  logic [NBANK-1:0]      dir_we,
  input  logic [NBANK-1:0]      ren_we,
  input  logic [NBANK-1:0]      fen_we,
  input  logic [2*NBANK-1:0]    alt_we,
  input  logic [NBANK*32-1:0]   set_mask,
  input  logic [NBANK*32-1:0]   clr_mask,
  output logic [NBANK*32-1:0]   dir,
  output logic [NBANK*32-1:0]   out_val,
  output logic [NBANK*32-1:0]   rise_en,
  output logic [NBANK*32-1:0]   fall_en,
  output logic [NBANK*64-1:0]   alt
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir[b*32 +: 32]     <= '0;
        out_val[b*32 +: 32] <= '0;
        rise_en[b*32 +: 32] <= '0;
        fall_en[b*32 +: 32] <= '0;
      end else begin
        if (dir_we[b]) dir[b*32 +: 32]     <= wdata;
        if (ren_we[b]) rise_en[b*32 +: 32] <= wdata;
        if (fen_we[b]) fall_en[b*32 +: 32] <= wdata;
        out_val[b*32 +: 32] <= (out_val[b*32 +: 32] | set_mask[b*32 +: 32])
                               & ~clr_mask[b*32 +: 32];
      end
    end
  end

  for (genvar h = 0; h < 2 * NBANK; h++) begin : g_alt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        alt[h*32 +: 32] <= '0;
      else if (alt_we[h]) alt[h*32 +: 32] <= wdata;
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NPIN = 64,
  localparam int NBANK = NPIN / 32,
  localparam int NWORD = 9 * NBANK,
  localparam int AW = $clog2(NWORD * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_out,
  output logic [2*NPIN-1:0] alt_sel,
  output logic              irq
);
  import gpio_pkg::*;

  int unsigned  widx;
  int unsigned  slot;
  grp_e         grp;
  logic         wr_hit;
  logic         rd_hit;

  logic [NPIN-1:0]   lvl_sync;
  logic [NPIN-1:0]   dir_q, out_q, ren_q, fen_q, sts_q, edge_evt;
  logic [NPIN-1:0]   set_mask, clr_mask, sts_clr;
  logic [2*NPIN-1:0] alt_q;
  logic [NBANK-1:0]  dir_we, ren_we, fen_we;
  logic [2*NBANK-1:0] alt_we;
  logic [31:0]       rd_word;

  assign widx   = int'(bus_addr[AW-1:2]);
  assign grp    = word_group(widx, NBANK);
  assign slot   = word_slot(widx, NBANK);
  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & ~bus_wr;

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    logic bsel;
    assign bsel      = wr_hit && (slot == b);
    assign dir_we[b] = bsel && (grp == GRP_DIR);
    assign ren_we[b] = bsel && (grp == GRP_REN);
    assign fen_we[b] = bsel && (grp == GRP_FEN);
    assign set_mask[b*32 +: 32] = (bsel && grp == GRP_SET) ? bus_wdata : '0;
    assign clr_mask[b*32 +: 32] = (bsel && grp == GRP_CLR) ? bus_wdata : '0;
    assign sts_clr[b*32 +: 32]  = (bsel && grp == GRP_STS) ? bus_wdata : '0;
  end

  for (genvar h = 0; h < 2 * NBANK; h++) begin : g_adec
    assign alt_we[h] = wr_hit && (grp == GRP_ALT) && (slot == h);
  end

  gpio_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .q_out(lvl_sync)
  );

  gpio_regs #(.NBANK(NBANK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
    .dir_we(dir_we), .ren_we(ren_we), .fen_we(fen_we), .alt_we(alt_we),
    .set_mask(set_mask), .clr_mask(clr_mask),
    .dir(dir_q), .out_val(out_q), .rise_en(ren_q), .fall_en(fen_q), .alt(alt_q)
  );

  gpio_edge #(.NBANK(NBANK)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .rise_en(ren_q), .fall_en(fen_q),
    .clr_mask(sts_clr), .evt(edge_evt), .status(sts_q)
  );

  always_comb begin
    rd_word = '0;
    if (slot < NBANK) begin
      case (grp)
        GRP_LVL: rd_word = lvl_sync[slot*32 +: 32];
        GRP_DIR: rd_word = dir_q[slot*32 +: 32];
        GRP_REN: rd_word = ren_q[slot*32 +: 32];
        GRP_FEN: rd_word = fen_q[slot*32 +: 32];
        GRP_STS: rd_word = sts_q[slot*32 +: 32];
        default: rd_word = '0;
      endcase
    end
    if (grp == GRP_ALT && slot < 2 * NBANK) rd_word = alt_q[slot*32 +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= rd_word;
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q;
  assign alt_sel = alt_q;
  assign irq     = |sts_q;

  // R4: a set write raises every written pin on the next edge
  a_r4_set_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((pin_out & $past(set_mask)) == $past(set_mask)));
  // R4: a clear write lowers every written pin on the next edge
  a_r4_clr_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((pin_out & $past(clr_mask)) == '0));
  // R4: untouched outputs hold when no set or clear word is written
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask == '0 && clr_mask == '0) |=> $stable(pin_out));
  // R11: an unmapped read returns zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && widx >= NWORD) |=> (bus_rdata == '0));
  // R9: the interrupt falls only after a status-clearing write
  a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(|sts_clr));
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  localparam int NPIN  = 64;
  localparam int NBANK = NPIN / 32;
  localparam int AW    = $clog2(9 * NBANK * 4);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NPIN-1:0]   pin_in = '0;
  logic [NPIN-1:0]   pin_oe, pin_out;
  logic [2*NPIN-1:0] alt_sel;
  logic              irq;

  int n_chk = 0, n_bad = 0;
  logic [NPIN-1:0]   m_dir = '0, m_out = '0, m_ren = '0, m_fen = '0, m_sts = '0;
  logic [2*NPIN-1:0] m_alt = '0;

  always #2 clk = ~clk;

  gpio_bank_ctrl #(.NPIN(NPIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .alt_sel(alt_sel), .irq(irq)
  );

  function automatic logic [AW-1:0] adr(int g, int b);
    return AW'(g * NBANK * 4 + b * 4);
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic drive_pins(logic [NPIN-1:0] nv);
    @(negedge clk);
    m_sts = m_sts | (nv & ~pin_in & m_ren) | (~nv & pin_in & m_fen);
    pin_in = nv;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    check({tag, " pin_oe"}, 128'(pin_oe), 128'(m_dir));
    check({tag, " pin_out"}, 128'(pin_out), 128'(m_out));
    check({tag, " alt_sel"}, 128'(alt_sel), 128'(m_alt));
    check({tag, " irq"}, 128'(irq), 128'(|m_sts));
    for (int b = 0; b < NBANK; b++) begin
      rd(adr(6, b), d);
      check({tag, " status word"}, 128'(d), 128'(m_sts[b*32 +: 32]));
    end
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", 128'(pin_oe), 0);
    check("R1 out", 128'(pin_out), 0);
    check("R1 alt", 128'(alt_sel), 0);
    check("R1 irq", 128'(irq), 0);
    for (int g = 0; g < 8; g++) begin
      rd(adr(g, 0), d);
      check("R1 register zero", 128'(d), 0);
    end

    // R2/R3 direction by bank: pin 37 is bank 1 bit 5
    wr(adr(1, 1), 32'h0000_0020);
    m_dir[37] = 1'b1;
    check("R2 R3 pin37 output", 128'(pin_oe), 128'(m_dir));
    rd(adr(1, 1), d);
    check("R3 dir readback", 128'(d), 32'h20);

    // R4 set/clear with zero bits untouched; readback 0
    wr(adr(2, 0), 32'h0000_00F0); m_out[7:4] = 4'hF;
    wr(adr(2, 1), 32'h8000_0000); m_out[63] = 1'b1;
    check("R4 set", 128'(pin_out), 128'(m_out));
    wr(adr(3, 0), 32'h0000_0030); m_out[5:4] = 2'b00;
    check("R4 clear", 128'(pin_out), 128'(m_out));
    rd(adr(2, 0), d); check("R4 set reads zero", 128'(d), 0);
    rd(adr(3, 1), d); check("R4 clear reads zero", 128'(d), 0);

    // R5 level readback and write ignored
    drive_pins(64'hDEAD_BEEF_0123_4567);
    rd(adr(0, 0), d); check("R5 level bank0", 128'(d), 32'h0123_4567);
    wr(adr(0, 1), 32'h0);
    rd(adr(0, 1), d); check("R5 level write ignored", 128'(d), 32'hDEAD_BEEF);
    check("R5 level write no output effect", 128'(pin_out), 128'(m_out));
    drive_pins('0);

    // R6 disabled edges set nothing
    drive_pins(64'hFFFF_FFFF_FFFF_FFFF);
    drive_pins('0);
    check("R6 disabled edges", 128'(irq), 0);

    // R6 rising on pin 40, R9 irq
    wr(adr(4, 1), 32'h0000_0100); m_ren[40] = 1'b1;
    drive_pins(64'h0000_0100_0000_0000);
    check_all("R6 R9 rising");
    // falling not enabled yet
    drive_pins('0);
    check_all("R6 falling disabled");

    // R7 clearing with zero bits is a no-op, then W1C
    wr(adr(6, 1), 32'h0000_0000);
    check_all("R7 zero write keeps");
    wr(adr(6, 1), 32'h0000_0100); m_sts[40] = 1'b0;
    check_all("R7 w1c");

    // R8 edge coincides with clearing write: falling edge on pin 2
    wr(adr(5, 0), 32'h0000_0004); m_fen[2] = 1'b1;
    wr(adr(4, 0), 32'h0000_0004); m_ren[2] = 1'b1;
    drive_pins(64'h4);
    @(negedge clk);
    pin_in = '0;
    @(negedge clk);          // sync stage 1 loaded
    @(negedge clk);          // sync stage 2 loaded; edge visible this cycle
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = adr(6, 0); bus_wdata = 32'h4;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 edge wins irq", 128'(irq), 1);
    rd(adr(6, 0), d); check("R8 edge wins status", 128'(d), 32'h4);
    wr(adr(6, 0), 32'h4); m_sts[2] = 1'b0;
    check("R9 irq drops", 128'(irq), 0);

    // R10 alternate function: pin 17 -> word 7*NBANK+1 bits 3:2; pin 50 -> +3 bits 5:4
    wr(adr(7, 0) + AW'(4), 32'h0000_000C); m_alt[35:34] = 2'b11;
    wr(adr(7, 0) + AW'(12), 32'h0000_0020); m_alt[101:100] = 2'b10;
    check("R10 alt pins", 128'(alt_sel), 128'(m_alt));
    rd(adr(7, 0) + AW'(12), d); check("R10 alt readback", 128'(d), 32'h20);

    // R11 unmapped read
    rd(AW'(9 * NBANK * 4), d); check("R11 unmapped", 128'(d), 0);

    // random mix
    for (int i = 0; i < 120; i++) begin
      int op;
      int b;
      logic [31:0] v;
      op = int'($urandom % 7);
      b  = int'($urandom % NBANK);
      v  = $urandom;
      case (op)
        0: begin wr(adr(1, b), v); m_dir[b*32 +: 32] = v; end
        1: begin wr(adr(2, b), v); m_out[b*32 +: 32] |= v; end
        2: begin wr(adr(3, b), v); m_out[b*32 +: 32] &= ~v; end
        3: begin wr(adr(4, b), v); m_ren[b*32 +: 32] = v; end
        4: begin wr(adr(5, b), v); m_fen[b*32 +: 32] = v; end
        5: begin wr(adr(6, b), v); m_sts[b*32 +: 32] &= ~v; end
        default: begin
          int h;
          h = int'($urandom % (2 * NBANK));
          wr(adr(7, 0) + AW'(h * 4), v); m_alt[h*32 +: 32] = v;
        end
      endcase
      drive_pins({$urandom, $urandom});
      check_all("R3 R4 R6 R7 R9 R10 random");
      rd(adr(0, b), d);
      check("R5 random level", 128'(d), 128'(pin_in[b*32 +: 32]));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule